// File: doc/BRIEF.md
# Coprocessor operand transfer sequencer

This block is a bus master that moves one data operand between memory and a coprocessor's data port when the coprocessor asks for it. The data port sits at a fixed I/O address. Each transfer is made of bus operations that run back to back. The first operation reads from the source and the last one writes to the destination. A read captures data into a holding register, and a later write drives that register out.

Each bus operation starts with one status cycle, followed by one or more command cycles. A ready input, sampled at the end of every command cycle, either ends the operation or adds one more command cycle. The acknowledge output is active for the whole of the first operation of each sequence, so the coprocessor knows when to lower its request.

The memory side handles alignment. A word-aligned operand takes one memory cycle. An odd-aligned operand is split into two byte cycles: the low byte goes to or from the odd address, and the high byte goes to or from the next address.

Top module: `cop_xfer_seq`

## Requirements
- R1: With `rst` high at a clock edge, the sequencer is idle after that edge: `bus_stat` = 2'b11, `xfer_ack` = 0, `wr_data` = 0, and `bus_mem` and `bus_byte` are low.
- R2: While idle, a sequence starts only when `xfer_req` is sampled high. The status cycle of the first operation is visible in the next cycle. With `xfer_req` low, the block stays idle. `to_mem` and `oper_addr` are latched at the start, and later changes to them have no effect on the running sequence.
- R3: `bus_stat` is 2'b01 for a read and 2'b10 for a write. It holds that code only during the single status cycle of an operation and is 2'b11 in every other cycle. `bus_addr`, `bus_mem` and `bus_byte` are valid in both the status and the command cycles.
- R4: With `to_mem` = 0 (memory to coprocessor), the sequence first does a memory read at the operand address (`bus_mem` = 1). It then does an I/O write (`bus_mem` = 0) to `PORT_ADDR`, which defaults to 0x00FA.
- R5: With `to_mem` = 1 (coprocessor to memory), the sequence first does an I/O read at `PORT_ADDR`. It then does a memory write at the operand address.
- R6: `xfer_ack` is high in the status cycle and in all command cycles of the first operation of a sequence, and low at all other times.
- R7: A command cycle that ends with `bus_ready` low is followed by another command cycle. Address and select stay unchanged. The operation completes at the first command cycle that ends with `bus_ready` high.
- R8: When `oper_addr[0]` = 1, the memory side is split into two byte operations with `bus_byte` = 1. The first uses the operand address and carries the low byte. The second uses operand address + 1 and carries the high byte. Byte data travels on bits [7:0] of `rd_data` and `wr_data`. With `oper_addr[0]` = 0, the memory side is a single word operation with `bus_byte` = 0.
- R9: Read data is captured on the command cycle that ends with `bus_ready` high. During a write, `wr_data` carries the whole captured word, or for a byte write the selected byte in [7:0] with zero above it. During reads and idle, `wr_data` is 0.
- R10: After the last operation completes, there is at least one idle cycle, even if `xfer_req` stays high. A new sequence then begins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_req | input | 1 | Transfer request from the coprocessor |
| to_mem | input | 1 | Direction: 1 = coprocessor to memory, 0 = memory to coprocessor |
| oper_addr | input | ADDR_W | Operand memory address |
| bus_ready | input | 1 | Ready, sampled at the end of each command cycle |
| rd_data | input | DATA_W | Read data returned by the bus |
| bus_addr | output | ADDR_W | Address of the current operation |
| bus_mem | output | 1 | 1 = memory operation, 0 = I/O operation |
| bus_stat | output | 2 | Status: 01 read, 10 write, 11 none |
| bus_byte | output | 1 | Byte-wide operation |
| wr_data | output | DATA_W | Write data |
| xfer_ack | output | 1 | Acknowledge, active during the first operation |

## Verification
Every result of this block appears one clock after the edge that caused it:
- The first status cycle appears one edge after the request is seen in idle.
- The first command cycle appears one edge after each status cycle.
- The next status cycle, or idle, appears one edge after a command cycle that ends with ready high.

The bench drives all inputs on falling edges and checks outputs on the following falling edge. Each check therefore looks at exactly the cycle that one rising edge produced. A sequence that lasts for the ops of one transfer plus their wait states is walked cycle by cycle, with the ready value for each command cycle set in that same cycle.

// File: rtl/cop_xfer_pkg.sv
package cop_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STAT = 2'd1,
    ST_CMD  = 2'd2
  } seq_state_e;

  localparam logic [1:0] STAT_RD   = 2'b01;
  localparam logic [1:0] STAT_WR   = 2'b10;
  localparam logic [1:0] STAT_NONE = 2'b11;

  typedef struct packed {
    logic is_mem;
    logic is_write;
    logic is_byte;
    logic hi_part;
  } bus_op_t;

  // Number of bus operations in one sequence.
  function automatic logic [1:0] ops_in_seq(input logic odd);
    return odd ? 2'd3 : 2'd2;
  endfunction

  // Kind of operation at position idx of a sequence.
  function automatic bus_op_t plan_op(input logic to_mem, input logic odd,
                                      input logic [1:0] idx);
    bus_op_t    o;
    logic [1:0] last;
    last = ops_in_seq(odd) - 2'd1;
    if (to_mem) begin
      o.is_mem   = (idx != 2'd0);
      o.is_write = (idx != 2'd0);
    end else begin
      o.is_mem   = (idx != last);
      o.is_write = (idx == last);
    end
    o.is_byte = odd & o.is_mem;
    o.hi_part = o.is_byte & (to_mem ? (idx == 2'd2) : (idx == 2'd1));
    return o;
  endfunction

endpackage

// File: rtl/cop_xfer_fsm.sv
module cop_xfer_fsm
  import cop_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic       ready,
  input  logic [1:0] n_ops,
  output seq_state_e state,
  output logic [1:0] op_idx,
  output logic       seq_start,
  output logic       op_done,
  output logic       seq_done
);

  assign seq_start = (state == ST_IDLE) && req;
  assign op_done   = (state == ST_CMD) && ready;
  assign seq_done  = op_done && (op_idx == n_ops - 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      op_idx <= 2'd0;
    end else begin
      case (state)
        ST_IDLE: begin
          op_idx <= 2'd0;
          if (req) state <= ST_STAT;
        end
        ST_STAT: state <= ST_CMD;
        ST_CMD: begin
          if (ready) begin
            if (seq_done) begin
              state  <= ST_IDLE;
              op_idx <= 2'd0;
            end else begin
              state  <= ST_STAT;
              op_idx <= op_idx + 2'd1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cop_xfer_plan.sv
module cop_xfer_plan
  import cop_xfer_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 24,
  parameter logic [ADDR_W-1:0]  PORT_ADDR = 'hFA
) (
  input  logic              to_mem,
  input  logic              odd,
  input  logic [1:0]        idx,
  input  logic [ADDR_W-1:0] base_addr,
  output bus_op_t           op,
  output logic [ADDR_W-1:0] op_addr
);

  always_comb begin
    op = plan_op(to_mem, odd, idx);
    if (op.is_mem) op_addr = base_addr + ADDR_W'(op.hi_part);
    else           op_addr = PORT_ADDR;
  end

endmodule

// File: rtl/cop_xfer_dbuf.sv
module cop_xfer_dbuf #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              drive_en,
  input  logic              is_byte,
  input  logic              hi_part,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] wr_data
);

  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (cap_en) begin
      if (!is_byte)    hold_q                   <= rd_data;
      else if (hi_part) hold_q[DATA_W-1:HALF]   <= rd_data[HALF-1:0];
      else              hold_q[HALF-1:0]        <= rd_data[HALF-1:0];
    end
  end

  always_comb begin
    if (!drive_en)    wr_data = '0;
    else if (!is_byte) wr_data = hold_q;
    else if (hi_part)  wr_data = {{(DATA_W-HALF){1'b0}}, hold_q[DATA_W-1:HALF]};
    else               wr_data = {{(DATA_W-HALF){1'b0}}, hold_q[HALF-1:0]};
  end

endmodule

// File: rtl/cop_xfer_seq.sv
module cop_xfer_seq
  import cop_xfer_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 24,
  parameter int unsigned       DATA_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'hFA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_req,
  input  logic              to_mem,
  input  logic [ADDR_W-1:0] oper_addr,
  input  logic              bus_ready,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_mem,
  output logic [1:0]        bus_stat,
  output logic              bus_byte,
  output logic [DATA_W-1:0] wr_data,
  output logic              xfer_ack
);

  seq_state_e        state;
  logic [1:0]        op_idx;
  logic              seq_start, op_done, seq_done;
  logic              in_stat, in_cmd, active;
  logic              to_mem_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        n_ops;
  bus_op_t           op;
  logic [ADDR_W-1:0] op_addr;
  logic              cap_en, drive_en;

  // Latch the sequence context at start.
  always_ff @(posedge clk) begin
    if (rst) begin
      to_mem_q <= 1'b0;
      addr_q   <= '0;
    end else if (seq_start) begin
      to_mem_q <= to_mem;
      addr_q   <= oper_addr;
    end
  end

  assign n_ops = ops_in_seq(addr_q[0]);

  cop_xfer_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req       (xfer_req),
    .ready     (bus_ready),
    .n_ops     (n_ops),
    .state     (state),
    .op_idx    (op_idx),
    .seq_start (seq_start),
    .op_done   (op_done),
    .seq_done  (seq_done)
  );

  cop_xfer_plan #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_plan (
    .to_mem    (to_mem_q),
    .odd       (addr_q[0]),
    .idx       (op_idx),
    .base_addr (addr_q),
    .op        (op),
    .op_addr   (op_addr)
  );

  assign in_stat  = (state == ST_STAT);
  assign in_cmd   = (state == ST_CMD);
  assign active   = in_stat | in_cmd;
  assign cap_en   = op_done & ~op.is_write;
  assign drive_en = active & op.is_write;

  cop_xfer_dbuf #(.DATA_W(DATA_W)) u_dbuf (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (cap_en),
    .drive_en (drive_en),
    .is_byte  (op.is_byte),
    .hi_part  (op.hi_part),
    .rd_data  (rd_data),
    .wr_data  (wr_data)
  );

  assign bus_addr = active ? op_addr : '0;
  assign bus_mem  = active & op.is_mem;
  assign bus_byte = active & op.is_byte;
  assign bus_stat = in_stat ? (op.is_write ? STAT_WR : STAT_RD) : STAT_NONE;
  assign xfer_ack = active & (op_idx == 2'd0);

endmodule

// File: rtl/cop_xfer_seq_chk.sv
module cop_xfer_seq_chk #(
  parameter int unsigned       ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'hFA
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        bus_stat,
  input logic              xfer_ack,
  input logic              in_cmd,
  input logic              bus_ready,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_mem,
  input logic              bus_byte,
  input logic              seq_done
);

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: the cycle after a reset edge is idle
  always @(posedge clk) begin
    if (rst_q) begin
      assert_reset_idle_R1: assert (bus_stat == 2'b11 && !xfer_ack && !in_cmd);
    end
  end

  assert_stat_single_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_stat != 2'b11) |=> (bus_stat == 2'b11));

  // R4 and R5: every I/O operation targets the data port
  assert_io_port_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_stat != 2'b11 && !bus_mem) |-> (bus_addr == PORT_ADDR));

  assert_ack_starts_stat_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_ack) |-> (bus_stat != 2'b11));

  assert_wait_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (in_cmd && !bus_ready) |=> (in_cmd && $stable(bus_addr) && $stable(bus_mem)));

  assert_byte_is_mem_R8: assert property (@(posedge clk) disable iff (rst)
    bus_byte |-> bus_mem);

  assert_idle_gap_R10: assert property (@(posedge clk) disable iff (rst)
    seq_done |=> (bus_stat == 2'b11 && !xfer_ack && !in_cmd));

endmodule

bind cop_xfer_seq cop_xfer_seq_chk #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_stat  (bus_stat),
  .xfer_ack  (xfer_ack),
  .in_cmd    (in_cmd),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .bus_mem   (bus_mem),
  .bus_byte  (bus_byte),
  .seq_done  (seq_done)
);

// File: tb/cop_xfer_seq_tb.sv
module cop_xfer_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xfer_req = 1'b0;
  logic        to_mem = 1'b0;
  logic [23:0] oper_addr = '0;
  logic        bus_ready = 1'b0;
  logic [15:0] rd_data = '0;
  logic [23:0] bus_addr;
  logic        bus_mem;
  logic [1:0]  bus_stat;
  logic        bus_byte;
  logic [15:0] wr_data;
  logic        xfer_ack;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  cop_xfer_seq u_dut (
    .clk(clk), .rst(rst), .xfer_req(xfer_req), .to_mem(to_mem),
    .oper_addr(oper_addr), .bus_ready(bus_ready), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_mem(bus_mem), .bus_stat(bus_stat),
    .bus_byte(bus_byte), .wr_data(wr_data), .xfer_ack(xfer_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Expected operation shape, written from the requirements.
  function automatic int e_count(bit odd);
    return odd ? 3 : 2;
  endfunction
  function automatic bit e_mem(bit d, bit odd, int i);
    if (d) return i > 0;
    return i < e_count(odd) - 1;
  endfunction
  function automatic bit e_wr(bit d, bit odd, int i);
    if (d) return i > 0;
    return i == e_count(odd) - 1;
  endfunction
  function automatic bit e_hi(bit d, bit odd, int i);
    if (!odd) return 1'b0;
    return d ? (i == 2) : (i == 1);
  endfunction
  function automatic logic [23:0] e_addr(bit d, logic [23:0] a, int i);
    if (!e_mem(d, a[0], i)) return 24'h0000FA;
    return e_hi(d, a[0], i) ? a + 24'd1 : a;
  endfunction

  task automatic check_idle(input string tag);
    chk({tag, " stat"}, 32'(bus_stat), 32'h3);
    chk({tag, " ack"}, 32'(xfer_ack), 32'h0);
    chk({tag, " wdata"}, 32'(wr_data), 32'h0);
  endtask

  task automatic run_seq(input bit d, input logic [23:0] a, input int maxw, input bit hold_req);
    logic [15:0] word;
    bit          odd;
    odd  = a[0];
    word = '0;
    @(negedge clk);
    xfer_req = 1'b1; to_mem = d; oper_addr = a; bus_ready = 1'b0;
    for (int i = 0; i < e_count(odd); i++) begin
      int w;
      @(negedge clk);
      chk("R3 status code", 32'(bus_stat), e_wr(d, odd, i) ? 32'h2 : 32'h1);
      chk(d ? "R5 select" : "R4 select", 32'(bus_mem), 32'(e_mem(d, odd, i)));
      chk(d ? "R5 address" : "R4 address", 32'(bus_addr), 32'(e_addr(d, a, i)));
      chk("R8 byte flag", 32'(bus_byte), 32'(odd && e_mem(d, odd, i)));
      chk("R6 ack in status", 32'(xfer_ack), 32'(i == 0));
      if (!hold_req) xfer_req = 1'b0;
      to_mem = ~d; oper_addr = $urandom;   // R2: late changes ignored
      w = $urandom_range(maxw, 0);
      for (int c = 0; c <= w; c++) begin
        logic [15:0] rd;
        @(negedge clk);
        chk("R7 command stat", 32'(bus_stat), 32'h3);
        chk("R7 address held", 32'(bus_addr), 32'(e_addr(d, a, i)));
        chk("R6 ack in command", 32'(xfer_ack), 32'(i == 0));
        if (e_wr(d, odd, i)) begin
          logic [15:0] ew;
          if (!odd || !e_mem(d, odd, i)) ew = word;
          else if (e_hi(d, odd, i))      ew = {8'h00, word[15:8]};
          else                           ew = {8'h00, word[7:0]};
          chk(odd ? "R8 byte write data" : "R9 write data", 32'(wr_data), 32'(ew));
        end else begin
          chk("R9 read drives zero", 32'(wr_data), 32'h0);
        end
        rd = 16'($urandom);
        rd_data = rd;
        bus_ready = (c == w);
        if (c == w && !e_wr(d, odd, i)) begin
          if (!odd || !e_mem(d, odd, i)) word = rd;
          else if (e_hi(d, odd, i))      word[15:8] = rd[7:0];
          else                           word[7:0]  = rd[7:0];
        end
      end
    end
    @(negedge clk);
    bus_ready = 1'b0;
    check_idle("R10 idle after sequence");
    if (hold_req) begin
      @(negedge clk);
      chk("R10 restart stat", 32'(bus_stat != 2'b11), 32'h1);
      chk("R10 restart ack", 32'(xfer_ack), 32'h1);
      xfer_req = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      check_idle("R1 reset mid sequence");
      rst = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset state");
    chk("R1 mem select", 32'(bus_mem), 32'h0);
    rst = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check_idle("R2 no request stays idle");
    end
    void'($urandom(32'd1234));
    // Directed corner cases
    run_seq(1'b0, 24'h001000, 0, 1'b0);
    run_seq(1'b1, 24'h002000, 0, 1'b0);
    run_seq(1'b0, 24'h003001, 3, 1'b0);
    run_seq(1'b1, 24'h00FFFF, 3, 1'b0);
    run_seq(1'b1, 24'h004005, 2, 1'b1);
    // Reset during a command cycle
    @(negedge clk);
    xfer_req = 1'b1; to_mem = 1'b0; oper_addr = 24'h000010;
    @(negedge clk);
    xfer_req = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_idle("R1 reset in command");
    rst = 1'b0;
    // Constrained random sequences
    for (int k = 0; k < 60; k++) begin
      run_seq(1'($urandom), 24'($urandom), 3, 1'b0);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule